// File: doc/BRIEF.md
# Selectable Conversion Trigger Generator

This block sits beside a pair of PWM counters, one even and one odd, and turns one chosen counter event into a start-of-conversion request for an analogue-to-digital converter. Each counter supplies single-cycle event strobes: reaching zero, reaching the period value, and matching its compare value while counting up or while counting down. Three free-running trigger comparators, one per even channel (pair index 0, 1 and 2), supply their own up-count and down-count match strobes. Those comparators hold a 16-bit compare value shared by a channel pair, which takes effect from the next period. The comparators and the counters sit outside this block.

A 4-bit source select from the register side picks the event. When the selected strobe is high and the trigger is enabled, the block emits a one-cycle pulse on the following clock edge and sets a sticky flag. Software clears the flag with a one-cycle clear strobe. A new event arriving in the same cycle as a clear takes precedence.

Top module: `adc_trig_sel`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, trig_pulse and trig_flag are both 0.
- R2: Source codes 0, 1, 2, 3 and 4 select the even channel's zero strobe, its period strobe, zero OR period, its compare-up strobe and its compare-down strobe.
- R3: Source codes 5, 6, 7, 8 and 9 select the odd channel's zero strobe, its period strobe, zero OR period, its compare-up strobe and its compare-down strobe.
- R4: Source codes 10 + 2k and 11 + 2k (k = 0, 1, 2) select fc_up[k] and fc_dn[k], the up-count and down-count matches of free comparator k.
- R5: trig_pulse is high for exactly the cycle after each clock edge at which trig_en is 1 and the selected strobe is 1. A strobe that is not selected produces no pulse.
- R6: While trig_en is 0, no pulse is produced and the flag is not set, whatever the strobes do.
- R7: trig_flag becomes 1 together with each trig_pulse, and stays 1 until it is cleared.
- R8: A flag_clr at a clock edge with no qualifying event makes trig_flag 0 after that edge.
- R9: When flag_clr and a qualifying event arrive at the same edge, trig_flag stays or becomes 1 and the pulse is still produced.
- R10: A selected strobe held high for several consecutive cycles gives a pulse in each of those cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_zero | input | 1 | Even counter reached zero |
| ev_prd | input | 1 | Even counter reached its period |
| ev_cmpu | input | 1 | Even counter matched compare while counting up |
| ev_cmpd | input | 1 | Even counter matched compare while counting down |
| od_zero | input | 1 | Odd counter reached zero |
| od_prd | input | 1 | Odd counter reached its period |
| od_cmpu | input | 1 | Odd counter matched compare while counting up |
| od_cmpd | input | 1 | Odd counter matched compare while counting down |
| fc_up | input | 3 | Free comparator k matched while counting up (bit k) |
| fc_dn | input | 3 | Free comparator k matched while counting down (bit k) |
| src_sel | input | 4 | Trigger source code |
| trig_en | input | 1 | Trigger enable |
| flag_clr | input | 1 | Clear strobe for the sticky flag |
| trig_pulse | output | 1 | One-cycle conversion trigger |
| trig_flag | output | 1 | Sticky trigger flag |

## Verification
The only state in the block is the pulse register and the flag. A wrong decode of the source code shows up as a missing or extra pulse one cycle after the strobe. A fault in the set or clear path of the flag shows up on the same edge as the pulse or the clear, and then persists until the next clear or event. The reference model is therefore compared on every cycle, so a wrong state is reported within one cycle of the stimulus that exposes it. Every code is swept against every strobe one at a time, and clears are placed both alone and on the same edge as an event.

// File: rtl/adc_trig_sel.sv
module adc_trig_sel #(
  parameter int FC_PAIRS = 3,
  parameter int SEL_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_zero,
  input  logic                ev_prd,
  input  logic                ev_cmpu,
  input  logic                ev_cmpd,
  input  logic                od_zero,
  input  logic                od_prd,
  input  logic                od_cmpu,
  input  logic                od_cmpd,
  input  logic [FC_PAIRS-1:0] fc_up,
  input  logic [FC_PAIRS-1:0] fc_dn,
  input  logic [SEL_W-1:0]    src_sel,
  input  logic                trig_en,
  input  logic                flag_clr,
  output logic                trig_pulse,
  output logic                trig_flag
);
  localparam int PER_CH = 5;
  localparam int NSRC   = 2 * PER_CH + 2 * FC_PAIRS;

  logic [PER_CH-1:0]     even_evt, odd_evt;
  logic [2*FC_PAIRS-1:0] free_evt;
  logic [NSRC-1:0]       src_vec;
  logic                  hit, fire;

  assign even_evt = {ev_cmpd, ev_cmpu, ev_zero | ev_prd, ev_prd, ev_zero};
  assign odd_evt  = {od_cmpd, od_cmpu, od_zero | od_prd, od_prd, od_zero};

  for (genvar k = 0; k < FC_PAIRS; k++) begin : g_free
    assign free_evt[2*k]   = fc_up[k];
    assign free_evt[2*k+1] = fc_dn[k];
  end

  assign src_vec = {free_evt, odd_evt, even_evt};

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (int'(src_sel) == i) hit = src_vec[i];
  end

  assign fire = trig_en & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_pulse <= 1'b0;
      trig_flag  <= 1'b0;
    end else begin
      trig_pulse <= fire;
      trig_flag  <= fire | (trig_flag & ~flag_clr);
    end
  end
endmodule

module adc_trig_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_zero,
  input logic       od_prd,
  input logic [3:0] src_sel,
  input logic       trig_en,
  input logic       flag_clr,
  input logic       trig_pulse,
  input logic       trig_flag
);
  AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) trig_pulse |-> $past(trig_en)); // R6
  AST_NO_SET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) !trig_en |=> !$rose(trig_flag)); // R6
  AST_FLAG_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n) trig_pulse |-> trig_flag); // R7
  AST_FLAG_RISE_SRC: assert property (@(posedge clk) disable iff (!rst_n) $rose(trig_flag) |-> trig_pulse); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (trig_flag && !flag_clr) |=> trig_flag); // R7
  AST_CLR_RESULT: assert property (@(posedge clk) disable iff (!rst_n) flag_clr |=> (trig_flag == trig_pulse)); // R8
  AST_EVEN_ZERO_SEL: assert property (@(posedge clk) disable iff (!rst_n) (trig_en && src_sel == 4'd0 && ev_zero) |=> (trig_pulse && trig_flag)); // R2
  AST_ODD_PRD_SEL: assert property (@(posedge clk) disable iff (!rst_n) (trig_en && src_sel == 4'd6 && od_prd) |=> (trig_pulse && trig_flag)); // R3
endmodule

bind adc_trig_sel adc_trig_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_zero(ev_zero), .od_prd(od_prd),
  .src_sel(src_sel), .trig_en(trig_en), .flag_clr(flag_clr),
  .trig_pulse(trig_pulse), .trig_flag(trig_flag)
);

// File: tb/sim_adc_trig_sel.sv
module sim_adc_trig_sel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [13:0] stb = '0;
  logic [3:0] sel = '0;
  logic en = 1'b0, clr = 1'b0;
  logic pulse, flag;

  int vectors = 0, errors = 0, cycles = 0;
  logic running = 1'b0;
  string req = "R1";

  logic m_pulse = 1'b0, m_flag = 1'b0;

  always #10 clk = ~clk;

  adc_trig_sel u0 (
    .clk(clk), .rst_n(rst_n),
    .ev_zero(stb[0]), .ev_prd(stb[1]), .ev_cmpu(stb[2]), .ev_cmpd(stb[3]),
    .od_zero(stb[4]), .od_prd(stb[5]), .od_cmpu(stb[6]), .od_cmpd(stb[7]),
    .fc_up(stb[10:8]), .fc_dn(stb[13:11]),
    .src_sel(sel), .trig_en(en), .flag_clr(clr),
    .trig_pulse(pulse), .trig_flag(flag)
  );

  function automatic logic want(input int code, input logic [13:0] s);
    int base, kind, n;
    if (code < 10) begin
      base = (code < 5) ? 0 : 4;
      kind = code % 5;
      case (kind)
        0: return s[base];
        1: return s[base+1];
        2: return s[base] | s[base+1];
        3: return s[base+2];
        default: return s[base+3];
      endcase
    end
    n = code - 10;
    if (n % 2 == 0) return s[8 + n/2];
    return s[11 + n/2];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pulse <= 1'b0;
      m_flag  <= 1'b0;
    end else begin
      m_pulse <= en && want(int'(sel), stb);
      if (en && want(int'(sel), stb)) m_flag <= 1'b1;
      else if (clr) m_flag <= 1'b0;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (running) begin
      vectors++;
      if (pulse !== m_pulse || flag !== m_flag) begin
        errors++;
        $display("FAIL %s: pulse/flag actual %b/%b expected %b/%b (sel=%0d en=%b clr=%b)",
                 req, pulse, flag, m_pulse, m_flag, sel, en, clr);
      end
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic step(input logic [13:0] s, input logic c);
    @(negedge clk);
    stb = s;
    clr = c;
  endtask

  initial begin
    running = 1'b1;
    req = "R1";
    repeat (3) @(negedge clk);
    stb = 14'h3fff; en = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    stb = '0; en = 1'b0;
    @(negedge clk);

    en = 1'b1;
    for (int code = 0; code < 16; code++) begin
      if (code < 5) req = "R2";
      else if (code < 10) req = "R3";
      else req = "R4";
      sel = code[3:0];
      for (int b = 0; b < 14; b++) begin
        step(14'(1) << b, 1'b0);
        step('0, 1'b0);
        step('0, 1'b1);
      end
    end

    req = "R5";
    sel = 4'd2;
    step(14'h0001, 1'b0);
    step(14'h0002, 1'b0);
    step(14'h3ffc, 1'b1);
    step('0, 1'b0);

    req = "R10";
    sel = 4'd13;
    for (int i = 0; i < 5; i++) step(14'h1000, 1'b0);
    step('0, 1'b1);

    req = "R6";
    en = 1'b0;
    for (int code = 0; code < 16; code++) begin
      sel = code[3:0];
      step(14'h3fff, 1'b0);
      step('0, 1'b0);
    end

    req = "R8";
    en = 1'b1; sel = 4'd8;
    step(14'h0040, 1'b0);
    step('0, 1'b0);
    step('0, 1'b1);
    step('0, 1'b0);

    req = "R9";
    step(14'h0040, 1'b1);
    step('0, 1'b0);
    step('0, 1'b1);
    step(14'h0040, 1'b1);
    step('0, 1'b0);

    req = "R7";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      sel = 4'($urandom_range(0, 15));
      en  = ($urandom_range(0, 7) != 0);
      clr = ($urandom_range(0, 5) == 0);
      stb = 14'($urandom) & 14'($urandom);
    end
    step('0, 1'b0);
    step('0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule